// File: doc/BRIEF.md
# Register Readiness Scoreboard with Consumer Wakeup

This block sits between rename/dispatch and the issue queue of an out-of-order core. It holds one ready bit for every physical register, with the integer and floating-point pools counted together. For each register it also records which queue entries are still waiting for that register. When an entry is dispatched, its source operands are checked. Sources already known ready are skipped. The other sources are looked up in the scoreboard, and the entry is linked as a waiter on each source register that is still pending. The entry's destination registers are marked not-ready, because the entry becomes their new producer.

When a producer completes, every waiter linked to its destination registers has one pending source retired. The waiter links of those registers are dropped and the registers become ready. A queue entry whose last pending source clears raises its bit on `entry_wake` for exactly one cycle. The issue logic uses that pulse to mark the entry as eligible. Tags at or beyond the tracked register count name registers that are not renamed. Such tags bypass all tracking.

Top module: `regsb_wakeup`

## Requirements
- R1: After reset every tracked register is not-ready, no entry waits, and `entry_wake` and `producer_clash` are low. A source that names any register and is not flagged ready therefore waits until that register completes.
- R2: A source whose bit in `disp_src_rdy` is 1 never waits. An entry whose sources are all flagged this way pulses its `entry_wake` bit in the cycle after dispatch.
- R3: A source not flagged ready, whose register the scoreboard already shows ready, counts as ready at insert. The entry pulses in the cycle after dispatch.
- R4: A source not flagged ready, whose register is not ready, links the entry as a waiter on that register. The entry pulses in the cycle after the completion of that register.
- R5: A source tag equal to or above NUM_PREGS (16 by default; tags are 5 bits) counts as ready.
- R6: A destination tag or completion tag equal to or above NUM_PREGS has no effect. It changes no ready bit, wakes no entry and raises no clash.
- R7: A dispatched destination register is marked not-ready from the next cycle on. This holds even when a completion for that same register arrives in the same cycle: the dispatch wins.
- R8: A completion wakes all entries waiting on that register together, in the same cycle, and leaves the register ready.
- R9: An entry with two distinct pending source registers pulses only after both have completed, in the cycle after the later completion.
- R10: Two sources of one entry that name the same pending register count as one pending source. A single completion wakes the entry.
- R11: When a source's register completes in the same cycle as the dispatch that reads it, the source counts as ready.
- R12: `producer_clash` pulses in the cycle after a dispatch whose in-range destination register still has linked waiters. It stays low when a completion of that register in the same cycle drops those waiters.
- R13: Each `entry_wake` bit is a single-cycle pulse. A cycle with neither dispatch nor completion produces no pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | A dispatch is presented this cycle |
| disp_entry | input | ENT_W (3) | Queue entry index being filled |
| disp_src | input | NUM_SRCS*TAG_W (10) | Source register tags, source 0 in the low bits |
| disp_src_rdy | input | NUM_SRCS (2) | Per-source ready flag from rename |
| disp_dst | input | NUM_DSTS*TAG_W (5) | Destination register tags of the dispatched entry |
| cmp_valid | input | 1 | A producer completes this cycle |
| cmp_dst | input | NUM_DSTS*TAG_W (5) | Destination tags of the completing producer |
| entry_wake | output | NUM_ENTRIES (8) | One-cycle pulse per entry whose sources all became ready |
| producer_clash | output | 1 | Pulse: a new producer was assigned to a register that still has waiters |

## Verification
A single stream of dispatches and completions drives the wakeup function through several kinds of sources: sources flagged ready at rename, sources that the scoreboard finds already ready, out-of-range tags, and sources that must wait. Comparing these separates the skip path, the recheck path and the link path. Further patterns cover two pending sources on distinct registers, two sources on one register, and several entries waiting on one register. These show whether the pending count tracks distinct registers and whether one completion fans out to all of its waiters. Same-cycle collisions test the chosen priorities: a completion that meets a dependent insert, and a completion that meets a new producer. A mid-run reset checks that a register earlier made ready reverts to waiting.

// File: rtl/regsb_pkg.sv
package regsb_pkg;
    // Default geometry shared by the scoreboard, its helpers and its checker.
    localparam int DEF_PREGS   = 16;
    localparam int DEF_ENTRIES = 8;
    localparam int DEF_SRCS    = 2;
    localparam int DEF_DSTS    = 1;
endpackage

// File: rtl/regsb_src_eval.sv
module regsb_src_eval #(
    parameter int NUM_PREGS = 16,
    parameter int TAG_W     = 5
) (
    input  logic                 en,
    input  logic [TAG_W-1:0]     tag,
    input  logic                 renamed_rdy,
    input  logic [NUM_PREGS-1:0] ready_vec,
    input  logic [NUM_PREGS-1:0] cmp_hit,
    output logic                 pend,
    output logic [NUM_PREGS-1:0] pend_onehot
);
    localparam int PIDX_W = $clog2(NUM_PREGS);
    localparam logic [TAG_W-1:0] TAG_LIM = TAG_W'(NUM_PREGS);

    logic              in_rng;
    logic [PIDX_W-1:0] idx;

    always_comb begin
        in_rng      = (tag < TAG_LIM);
        idx         = tag[PIDX_W-1:0];
        pend        = en && !renamed_rdy && in_rng && !ready_vec[idx] && !cmp_hit[idx];
        pend_onehot = '0;
        if (pend) pend_onehot[idx] = 1'b1;
    end
endmodule

// File: rtl/regsb_entry_track.sv
module regsb_entry_track #(
    parameter int NUM_PREGS = 16,
    parameter int CNT_W     = 2
) (
    input  logic                 load,
    input  logic [CNT_W-1:0]     load_cnt,
    input  logic [NUM_PREGS-1:0] wait_col,
    input  logic [NUM_PREGS-1:0] cmp_hit,
    input  logic [CNT_W-1:0]     cnt_q,
    output logic [CNT_W-1:0]     cnt_d,
    output logic                 pulse_d
);
    logic [CNT_W-1:0] dec;

    always_comb begin
        dec = CNT_W'($countones(wait_col & cmp_hit));
        if (load) begin
            cnt_d   = load_cnt;
            pulse_d = (load_cnt == '0);
        end else begin
            cnt_d   = cnt_q - dec;
            pulse_d = (cnt_q != '0) && (dec == cnt_q);
        end
    end
endmodule

// File: rtl/regsb_wakeup.sv
module regsb_wakeup
    import regsb_pkg::*;
#(
    parameter int NUM_PREGS   = DEF_PREGS,
    parameter int NUM_ENTRIES = DEF_ENTRIES,
    parameter int NUM_SRCS    = DEF_SRCS,
    parameter int NUM_DSTS    = DEF_DSTS,
    localparam int TAG_W = $clog2(NUM_PREGS) + 1,
    localparam int ENT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      disp_valid,
    input  logic [ENT_W-1:0]          disp_entry,
    input  logic [NUM_SRCS*TAG_W-1:0] disp_src,
    input  logic [NUM_SRCS-1:0]       disp_src_rdy,
    input  logic [NUM_DSTS*TAG_W-1:0] disp_dst,
    input  logic                      cmp_valid,
    input  logic [NUM_DSTS*TAG_W-1:0] cmp_dst,
    output logic [NUM_ENTRIES-1:0]    entry_wake,
    output logic                      producer_clash
);
    localparam int CNT_W = $clog2(NUM_SRCS + 1);

    typedef struct packed {
        logic [NUM_PREGS-1:0]                  rdy;
        logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] waitm;
        logic [NUM_ENTRIES-1:0][CNT_W-1:0]     cnt;
        logic [NUM_ENTRIES-1:0]                pulse;
        logic                                  clash;
    } sb_state_t;

    sb_state_t st_q, st_d;

    logic [NUM_PREGS-1:0]                  cmp_hit;
    logic [NUM_PREGS-1:0]                  dst_hit;
    logic [NUM_SRCS-1:0]                   src_pend;
    logic [NUM_SRCS-1:0][NUM_PREGS-1:0]    src_onehot;
    logic [NUM_PREGS-1:0]                  disp_row;
    logic [CNT_W-1:0]                      disp_cnt;
    logic [NUM_ENTRIES-1:0]                ent_load;
    logic [NUM_ENTRIES-1:0][NUM_PREGS-1:0] ent_col;
    logic [NUM_ENTRIES-1:0][CNT_W-1:0]     ent_cnt_d;
    logic [NUM_ENTRIES-1:0]                ent_pulse_d;
    logic [NUM_PREGS-1:0]                  rdy_q;
    logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] waitm_q;

    // Tag decode: out-of-range tags never match an index below NUM_PREGS.
    always_comb begin
        for (int r = 0; r < NUM_PREGS; r++) begin
            cmp_hit[r] = 1'b0;
            dst_hit[r] = 1'b0;
            for (int d = 0; d < NUM_DSTS; d++) begin
                if (cmp_valid && cmp_dst[d*TAG_W +: TAG_W] == TAG_W'(r))
                    cmp_hit[r] = 1'b1;
                if (disp_valid && disp_dst[d*TAG_W +: TAG_W] == TAG_W'(r))
                    dst_hit[r] = 1'b1;
            end
        end
    end

    for (genvar j = 0; j < NUM_SRCS; j++) begin : g_src
        regsb_src_eval #(
            .NUM_PREGS(NUM_PREGS),
            .TAG_W    (TAG_W)
        ) i_src_eval (
            .en         (disp_valid),
            .tag        (disp_src[j*TAG_W +: TAG_W]),
            .renamed_rdy(disp_src_rdy[j]),
            .ready_vec  (st_q.rdy),
            .cmp_hit    (cmp_hit),
            .pend       (src_pend[j]),
            .pend_onehot(src_onehot[j])
        );
    end

    // Distinct pending registers of the incoming entry.
    always_comb begin
        disp_row = '0;
        for (int j = 0; j < NUM_SRCS; j++) disp_row = disp_row | src_onehot[j];
        disp_cnt = CNT_W'($countones(disp_row));
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            ent_load[e] = disp_valid && (disp_entry == ENT_W'(e));
            for (int r = 0; r < NUM_PREGS; r++) ent_col[e][r] = st_q.waitm[r][e];
        end
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        regsb_entry_track #(
            .NUM_PREGS(NUM_PREGS),
            .CNT_W    (CNT_W)
        ) i_entry_track (
            .load    (ent_load[e]),
            .load_cnt(disp_cnt),
            .wait_col(ent_col[e]),
            .cmp_hit (cmp_hit),
            .cnt_q   (st_q.cnt[e]),
            .cnt_d   (ent_cnt_d[e]),
            .pulse_d (ent_pulse_d[e])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.clash = 1'b0;
        for (int r = 0; r < NUM_PREGS; r++) begin
            // New producer wins over a same-cycle completion.
            if (dst_hit[r])      st_d.rdy[r] = 1'b0;
            else if (cmp_hit[r]) st_d.rdy[r] = 1'b1;
            if (dst_hit[r] && (|st_q.waitm[r]) && !cmp_hit[r])
                st_d.clash = 1'b1;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (ent_load[e])     st_d.waitm[r][e] = disp_row[r];
                else if (cmp_hit[r]) st_d.waitm[r][e] = 1'b0;
            end
        end
        st_d.cnt   = ent_cnt_d;
        st_d.pulse = ent_pulse_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign entry_wake     = st_q.pulse;
    assign producer_clash = st_q.clash;
    assign rdy_q          = st_q.rdy;
    assign waitm_q        = st_q.waitm;
endmodule

// File: rtl/regsb_wakeup_chk.sv
module regsb_wakeup_chk #(
    parameter int NUM_PREGS   = 16,
    parameter int NUM_ENTRIES = 8,
    parameter int NUM_SRCS    = 2,
    parameter int NUM_DSTS    = 1,
    parameter int TAG_W       = 5,
    parameter int ENT_W       = 3
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  disp_valid,
    input logic [ENT_W-1:0]                      disp_entry,
    input logic [NUM_SRCS-1:0]                   disp_src_rdy,
    input logic [NUM_DSTS*TAG_W-1:0]             disp_dst,
    input logic                                  cmp_valid,
    input logic [NUM_DSTS*TAG_W-1:0]             cmp_dst,
    input logic [NUM_ENTRIES-1:0]                entry_wake,
    input logic                                  producer_clash,
    input logic [NUM_PREGS-1:0]                  rdy_q,
    input logic [NUM_PREGS-1:0][NUM_ENTRIES-1:0] waitm_q
);
    localparam int PIDX_W = $clog2(NUM_PREGS);
    localparam logic [TAG_W-1:0] TAG_LIM = TAG_W'(NUM_PREGS);

    p_cmp_sets_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst[TAG_W-1:0] < TAG_LIM && !disp_valid)
        |=> rdy_q[$past(cmp_dst[PIDX_W-1:0])]);

    p_cmp_drains_waiters_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_dst[TAG_W-1:0] < TAG_LIM && !disp_valid)
        |=> (waitm_q[$past(cmp_dst[PIDX_W-1:0])] == '0));

    p_dst_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_dst[TAG_W-1:0] < TAG_LIM)
        |=> !rdy_q[$past(disp_dst[PIDX_W-1:0])]);

    p_quiet_no_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_valid && !cmp_valid) |=> (entry_wake == '0));

    p_clash_needs_dispatch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        producer_clash |-> $past(disp_valid));

    p_renamed_ready_wakes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && (&disp_src_rdy)) |=> entry_wake[$past(disp_entry)]);
endmodule

bind regsb_wakeup regsb_wakeup_chk #(
    .NUM_PREGS  (NUM_PREGS),
    .NUM_ENTRIES(NUM_ENTRIES),
    .NUM_SRCS   (NUM_SRCS),
    .NUM_DSTS   (NUM_DSTS),
    .TAG_W      (TAG_W),
    .ENT_W      (ENT_W)
) i_regsb_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .disp_valid    (disp_valid),
    .disp_entry    (disp_entry),
    .disp_src_rdy  (disp_src_rdy),
    .disp_dst      (disp_dst),
    .cmp_valid     (cmp_valid),
    .cmp_dst       (cmp_dst),
    .entry_wake    (entry_wake),
    .producer_clash(producer_clash),
    .rdy_q         (rdy_q),
    .waitm_q       (waitm_q)
);

// File: tb/test_regsb_wakeup.sv
`timescale 1ns/1ps
module test_regsb_wakeup;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       disp_valid;
    logic [2:0] disp_entry;
    logic [9:0] disp_src;
    logic [1:0] disp_src_rdy;
    logic [4:0] disp_dst;
    logic       cmp_valid;
    logic [4:0] cmp_dst;
    logic [7:0] entry_wake;
    logic       producer_clash;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    regsb_wakeup i_regsb_wakeup (
        .clk           (clk),
        .rst_n         (rst_n),
        .disp_valid    (disp_valid),
        .disp_entry    (disp_entry),
        .disp_src      (disp_src),
        .disp_src_rdy  (disp_src_rdy),
        .disp_dst      (disp_dst),
        .cmp_valid     (cmp_valid),
        .cmp_dst       (cmp_dst),
        .entry_wake    (entry_wake),
        .producer_clash(producer_clash)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       cv;
        logic [4:0] ct;
        logic       dv;
        logic [2:0] ent;
        logic [4:0] s1;
        logic [4:0] s0;
        logic [1:0] rf;
        logic [4:0] dt;
        logic [7:0] ep;
        logic       ec;
    } vec_t;

    localparam int NVEC = 24;
    // Fields: req, cmp valid, cmp tag, disp valid, entry, src1, src0, rename flags, dst, expected wake, expected clash
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  1'b0, 5'd0,  1'b1, 3'd0, 5'd3,  5'd4,  2'b11, 5'd31, 8'h01, 1'b0}, // R2 flagged sources skipped
        '{4'd13, 1'b0, 5'd0,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h00, 1'b0}, // R13 pulse lasts one cycle
        '{4'd5,  1'b0, 5'd0,  1'b1, 3'd1, 5'd31, 5'd20, 2'b00, 5'd31, 8'h02, 1'b0}, // R5 out-of-range sources ready
        '{4'd4,  1'b0, 5'd0,  1'b1, 3'd2, 5'd5,  5'd31, 2'b00, 5'd31, 8'h00, 1'b0}, // R4 waits on reg 5
        '{4'd4,  1'b1, 5'd5,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h04, 1'b0}, // R4 completion of 5 wakes e2
        '{4'd3,  1'b0, 5'd0,  1'b1, 3'd3, 5'd5,  5'd5,  2'b00, 5'd31, 8'h08, 1'b0}, // R3 scoreboard recheck
        '{4'd9,  1'b0, 5'd0,  1'b1, 3'd4, 5'd6,  5'd7,  2'b00, 5'd31, 8'h00, 1'b0}, // R9 two pending
        '{4'd9,  1'b1, 5'd6,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h00, 1'b0}, // R9 one still pending
        '{4'd9,  1'b1, 5'd7,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h10, 1'b0}, // R9 both done
        '{4'd10, 1'b0, 5'd0,  1'b1, 3'd5, 5'd8,  5'd8,  2'b00, 5'd31, 8'h00, 1'b0}, // R10 same reg twice
        '{4'd8,  1'b0, 5'd0,  1'b1, 3'd6, 5'd31, 5'd8,  2'b00, 5'd31, 8'h00, 1'b0}, // R8 second waiter on 8
        '{4'd8,  1'b1, 5'd8,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h60, 1'b0}, // R8 R10 fan-out wake
        '{4'd11, 1'b1, 5'd9,  1'b1, 3'd7, 5'd9,  5'd31, 2'b00, 5'd31, 8'h80, 1'b0}, // R11 same-cycle bypass
        '{4'd7,  1'b0, 5'd0,  1'b1, 3'd0, 5'd31, 5'd9,  2'b00, 5'd5,  8'h01, 1'b0}, // R7 new producer of 5
        '{4'd7,  1'b0, 5'd0,  1'b1, 3'd1, 5'd31, 5'd5,  2'b00, 5'd31, 8'h00, 1'b0}, // R7 reg 5 not ready again
        '{4'd12, 1'b0, 5'd0,  1'b1, 3'd2, 5'd31, 5'd31, 2'b11, 5'd5,  8'h04, 1'b1}, // R12 clash with waiter e1
        '{4'd12, 1'b1, 5'd5,  1'b1, 3'd3, 5'd31, 5'd31, 2'b11, 5'd5,  8'h0A, 1'b0}, // R12 no clash, waiters drained
        '{4'd7,  1'b0, 5'd0,  1'b1, 3'd4, 5'd31, 5'd5,  2'b00, 5'd31, 8'h00, 1'b0}, // R7 dispatch beat completion
        '{4'd7,  1'b1, 5'd5,  1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h10, 1'b0}, // R7 wake e4
        '{4'd6,  1'b0, 5'd0,  1'b1, 3'd5, 5'd31, 5'd31, 2'b11, 5'd20, 8'h20, 1'b0}, // R6 out-of-range dst
        '{4'd6,  1'b1, 5'd20, 1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h00, 1'b0}, // R6 out-of-range completion
        '{4'd6,  1'b0, 5'd0,  1'b1, 3'd6, 5'd31, 5'd10, 2'b00, 5'd31, 8'h00, 1'b0}, // R6 waits on 10
        '{4'd6,  1'b1, 5'd31, 1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h00, 1'b0}, // R6 tag 31 wakes nothing
        '{4'd6,  1'b1, 5'd10, 1'b0, 3'd0, 5'd0,  5'd0,  2'b00, 5'd31, 8'h40, 1'b0}  // R6 real completion wakes e6
    };

    task automatic check(input string rq, input logic [7:0] exp_wake, input logic exp_clash);
        n_chk++;
        if (entry_wake !== exp_wake || producer_clash !== exp_clash) begin
            n_fail++;
            $display("FAIL %s wake=%h clash=%b expected wake=%h clash=%b",
                     rq, entry_wake, producer_clash, exp_wake, exp_clash);
        end
    endtask

    task automatic drive(input logic cv, input logic [4:0] ct, input logic dv,
                         input logic [2:0] ent, input logic [4:0] s1, input logic [4:0] s0,
                         input logic [1:0] rf, input logic [4:0] dt);
        cmp_valid    = cv;
        cmp_dst      = ct;
        disp_valid   = dv;
        disp_entry   = ent;
        disp_src     = {s1, s0};
        disp_src_rdy = rf;
        disp_dst     = dt;
    endtask

    task automatic cycle();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 5'd0, 1'b0, 3'd0, 5'd0, 5'd0, 2'b00, 5'd31);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 8'h00, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].cv, VECS[i].ct, VECS[i].dv, VECS[i].ent,
                  VECS[i].s1, VECS[i].s0, VECS[i].rf, VECS[i].dt);
            cycle();
            check($sformatf("R%0d", VECS[i].req), VECS[i].ep, VECS[i].ec);
        end

        // R1: a mid-run reset forgets that reg 5 was ready
        drive(1'b0, 5'd0, 1'b0, 3'd0, 5'd0, 5'd0, 2'b00, 5'd31);
        rst_n = 1'b0;
        cycle();
        check("R1", 8'h00, 1'b0);
        rst_n = 1'b1;
        drive(1'b0, 5'd0, 1'b1, 3'd0, 5'd31, 5'd5, 2'b00, 5'd31);
        cycle();
        check("R1", 8'h00, 1'b0);
        drive(1'b1, 5'd5, 1'b0, 3'd0, 5'd0, 5'd0, 2'b00, 5'd31);
        cycle();
        check("R4", 8'h01, 1'b0);
        // R13: the pulse drops again with idle inputs
        drive(1'b0, 5'd0, 1'b0, 3'd0, 5'd0, 5'd0, 2'b00, 5'd31);
        cycle();
        check("R13", 8'h00, 1'b0);
        // R2: a single flagged source together with an out-of-range one
        drive(1'b0, 5'd0, 1'b1, 3'd3, 5'd12, 5'd30, 2'b10, 5'd31);
        cycle();
        check("R2", 8'h08, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule